// File: doc/BRIEF.md
# RGB565 Brightness and Alpha Blender

This block is the last arithmetic step of a texture-mapping pixel path. Each transfer carries a sampled texel and the pixel already held in the destination frame buffer, both packed as RGB565. The texel is first darkened by a 6-bit brightness code. It is then mixed over the destination using a 6-bit global opacity code. Both codes act as a factor of (code+1)/64, so code 63 means unity. The blended pixel leaves with a write-enable, and the memory side uses it to decide whether the destination location gets overwritten.

A colour-key comparison runs on the raw texel. When keying is enabled and the texel matches the key colour, the write-enable is dropped, so the destination stays as it was. Brightness, opacity and key settings travel with each input transfer, so they may change from pixel to pixel.

The datapath has two register stages under one valid/ready handshake. With no back-pressure, every pixel takes exactly two cycles. When the consumer stalls, the whole pipe holds.

Top module: `rgb565_blend`

## Requirements
- R1: Pixels are 16-bit RGB565: red occupies bits 15..11, green bits 10..5 and blue bits 4..0, and every channel is processed on its own.
- R2: Each source channel c is scaled by the brightness code b (0..63) to floor(c*(b+1)/64).
- R3: Each output channel equals floor((s*(a+1) + d*(63-a))/64), where s is the scaled source channel, d the destination channel and a the opacity code (0..63).
- R4: With opacity code 63 the output equals the scaled source. With brightness code 63 as well, the output equals the raw texel.
- R5: When key enable is 1 and the raw texel equals the key colour, wr_en_o is 0 for that pixel. Otherwise it is 1.
- R6: When key enable is 0, wr_en_o is 1 whatever the texel and key values are.
- R7: An input accepted into an empty pipe while out_ready_i stays high appears on the output two clock edges later, with out_valid_o high.
- R8: While out_valid_o is 1 and out_ready_i is 0, pix_o and wr_en_o hold their values, out_valid_o stays 1 and in_ready_o is 0.
- R9: After reset, out_valid_o is 0 and in_ready_o is 1.
- R10: Brightness, opacity and key settings are sampled with the pixel in the same transfer, so each pixel uses its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input transfer valid |
| in_ready_o | output | 1 | Block can accept an input |
| src_i | input | 16 | Sampled texel, RGB565 |
| dst_i | input | 16 | Current destination pixel, RGB565 |
| bright_i | input | 6 | Brightness code, factor (code+1)/64 |
| alpha_i | input | 6 | Opacity code, factor (code+1)/64 |
| key_en_i | input | 1 | Colour-key enable |
| key_i | input | 16 | Colour-key value, RGB565 |
| out_valid_o | output | 1 | Output transfer valid |
| out_ready_i | input | 1 | Consumer can accept the output |
| pix_o | output | 16 | Blended pixel, RGB565 |
| wr_en_o | output | 1 | Write the pixel to the destination |

## Verification
The case hardest to reach from the ports is a full pipe that receives back-pressure while new pixels, each with different per-pixel settings, wait at the input. Only then does a wrong stage advance mix one pixel's opacity with another's data. The stimulus drops out_ready_i at random on about a third of the cycles and changes brightness, opacity and key on every offered pixel. A reference queue fed at each accepted input catches any misordering. A key hit is rare under random texels, so the key is forced to equal the texel on a share of cycles, and directed cases cover the extreme codes.

// File: rtl/rgb565_blend_pkg.sv
package rgb565_blend_pkg;
  localparam int PIX_W  = 16;
  localparam int CODE_W = 6;
  localparam int NUM_CH = 3;

  // channel 0 = red, 1 = green, 2 = blue
  function automatic int ch_width(int idx);
    return (idx == 1) ? 6 : 5;
  endfunction

  function automatic int ch_lsb(int idx);
    case (idx)
      0:       return 11;
      1:       return 5;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/rgb565_chan_scale.sv
module rgb565_chan_scale #(
  parameter int CW = 5,
  parameter int FW = 6
) (
  input  logic [CW-1:0] c_i,
  input  logic [FW-1:0] code_i,
  output logic [CW-1:0] c_o
);
  localparam int PW = CW + FW + 1;
  logic [PW-1:0] prod;

  assign prod = PW'(c_i) * (PW'(code_i) + PW'(1));
  assign c_o  = prod[FW +: CW];
endmodule

// File: rtl/rgb565_chan_mix.sv
module rgb565_chan_mix #(
  parameter int CW = 5,
  parameter int FW = 6
) (
  input  logic [CW-1:0] s_i,
  input  logic [CW-1:0] d_i,
  input  logic [FW-1:0] a_i,
  output logic [CW-1:0] o_o
);
  localparam int SW = CW + FW + 1;
  localparam logic [SW-1:0] FMAX = SW'((1 << FW) - 1);

  logic [SW-1:0] ws, wd, sum;

  // weights (a+1) and (63-a) add up to 64: the sum cannot exceed max*64
  assign ws  = SW'(s_i) * (SW'(a_i) + SW'(1));
  assign wd  = SW'(d_i) * (FMAX - SW'(a_i));
  assign sum = ws + wd;
  assign o_o = sum[FW +: CW];
endmodule

// File: rtl/rgb565_pipe_ctl.sv
module rgb565_pipe_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic out_ready_i,
  output logic adv_o,
  output logic in_ready_o,
  output logic out_valid_o
);
  logic v1_q, v2_q;

  // lockstep pipe: both stages move together when the tail can drain
  assign adv_o       = !v2_q || out_ready_i;
  assign in_ready_o  = adv_o;
  assign out_valid_o = v2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else if (adv_o) begin
      v1_q <= in_valid_i;
      v2_q <= v1_q;
    end
  end
endmodule

// File: rtl/rgb565_blend.sv
module rgb565_blend
  import rgb565_blend_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [PIX_W-1:0]  src_i,
  input  logic [PIX_W-1:0]  dst_i,
  input  logic [CODE_W-1:0] bright_i,
  input  logic [CODE_W-1:0] alpha_i,
  input  logic              key_en_i,
  input  logic [PIX_W-1:0]  key_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              wr_en_o
);
  logic adv;

  rgb565_pipe_ctl i_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .out_ready_i(out_ready_i),
    .adv_o      (adv),
    .in_ready_o (in_ready_o),
    .out_valid_o(out_valid_o)
  );

  // stage 1: brightness scale and key test
  logic [PIX_W-1:0]  scaled;
  logic [PIX_W-1:0]  s1_src_q, s1_dst_q;
  logic [CODE_W-1:0] s1_alpha_q;
  logic              s1_wen_q;
  logic              key_hit;

  assign key_hit = key_en_i && (src_i == key_i);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_scale
    localparam int W = ch_width(ch);
    localparam int L = ch_lsb(ch);
    rgb565_chan_scale #(.CW(W), .FW(CODE_W)) i_scale (
      .c_i   (src_i[L +: W]),
      .code_i(bright_i),
      .c_o   (scaled[L +: W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_src_q   <= '0;
      s1_dst_q   <= '0;
      s1_alpha_q <= '0;
      s1_wen_q   <= 1'b0;
    end else if (adv) begin
      s1_src_q   <= scaled;
      s1_dst_q   <= dst_i;
      s1_alpha_q <= alpha_i;
      s1_wen_q   <= !key_hit;
    end
  end

  // stage 2: source-over mix
  logic [PIX_W-1:0] mixed;
  logic [PIX_W-1:0] pix_q;
  logic             wen_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_mix
    localparam int W = ch_width(ch);
    localparam int L = ch_lsb(ch);
    rgb565_chan_mix #(.CW(W), .FW(CODE_W)) i_mix (
      .s_i(s1_src_q[L +: W]),
      .d_i(s1_dst_q[L +: W]),
      .a_i(s1_alpha_q),
      .o_o(mixed[L +: W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q <= '0;
      wen_q <= 1'b0;
    end else if (adv) begin
      pix_q <= mixed;
      wen_q <= s1_wen_q;
    end
  end

  assign pix_o   = pix_q;
  assign wr_en_o = wen_q;
endmodule

// File: rtl/rgb565_blend_chk.sv
module rgb565_blend_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic [15:0] src_i,
  input logic [5:0]  bright_i,
  input logic [5:0]  alpha_i,
  input logic        key_en_i,
  input logic [15:0] key_i,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [15:0] pix_o,
  input logic        wr_en_o
);
  logic fire;
  assign fire = in_valid_i && in_ready_o;

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(pix_o) && $stable(wr_en_o)));

  // R8
  stall_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  // R7
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !out_valid_o) |=> ##1 out_valid_o);

  // R4
  unity_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !out_valid_o && bright_i == 6'd63 && alpha_i == 6'd63)
      |=> ##1 (!$past(out_ready_i) || pix_o == $past(src_i, 2)));

  // R5
  key_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !out_valid_o && key_en_i && src_i == key_i)
      |=> ##1 (!$past(out_ready_i) || !wr_en_o));
endmodule

bind rgb565_blend rgb565_blend_chk i_chk (.*);

// File: tb/test_rgb565_blend.sv
`timescale 1ns/1ps
module test_rgb565_blend;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [15:0] src_i = '0, dst_i = '0, key_i = '0;
  logic [5:0]  bright_i = '0, alpha_i = '0;
  logic        key_en_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [15:0] pix_o;
  logic        wr_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [16:0] exp_q[$];

  always #4 clk_i = ~clk_i;

  rgb565_blend i_rgb565_blend (.*);

  function automatic int scale_ch(int c, int b);
    return (c * (b + 1)) / 64;
  endfunction

  function automatic int mix_ch(int s, int d, int a);
    return (s * (a + 1) + d * (63 - a)) / 64;
  endfunction

  function automatic logic [15:0] model(logic [15:0] s, logic [15:0] d, int b, int a);
    int r, g, bl;
    r  = mix_ch(scale_ch(int'(s[15:11]), b), int'(d[15:11]), a);
    g  = mix_ch(scale_ch(int'(s[10:5]),  b), int'(d[10:5]),  a);
    bl = mix_ch(scale_ch(int'(s[4:0]),   b), int'(d[4:0]),   a);
    return {r[4:0], g[5:0], bl[4:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, then score what happens at the next edge
  task automatic cycle(bit v, logic [15:0] s, logic [15:0] d, logic [5:0] b,
                       logic [5:0] a, bit ke, logic [15:0] k, bit rdy);
    logic [16:0] e;
    @(negedge clk_i);
    in_valid_i = v; src_i = s; dst_i = d; bright_i = b; alpha_i = a;
    key_en_i = ke; key_i = k; out_ready_i = rdy;
    #1;
    if (out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) check("R7 spurious output", 32'(out_valid_o), 32'd0);
      else begin
        e = exp_q.pop_front();
        // R1 R2 R3 R10 data, R5 R6 write enable
        check("R1 R2 R3 R10 pixel", 32'(pix_o), 32'(e[15:0]));
        check("R5 R6 write enable", 32'(wr_en_o), 32'(e[16]));
      end
    end
    if (out_valid_o && !out_ready_i) check("R8 in_ready blocked", 32'(in_ready_o), 32'd0);
    if (in_valid_i && in_ready_o)
      exp_q.push_back({!(ke && s == k), model(s, d, int'(b), int'(a))});
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) cycle(0, '0, '0, '0, '0, 0, '0, 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    logic        held_we;
    repeat (3) @(negedge clk_i);
    #1;
    // R9
    check("R9 out_valid after reset", 32'(out_valid_o), 32'd0);
    check("R9 in_ready after reset", 32'(in_ready_o), 32'd1);
    rst_ni = 1'b1;

    // R7 latency: empty pipe, ready high
    @(negedge clk_i);
    in_valid_i = 1; src_i = 16'h1234; dst_i = 16'h0; bright_i = 63; alpha_i = 63;
    key_en_i = 0; out_ready_i = 1;
    @(negedge clk_i); in_valid_i = 0; #1;
    check("R7 not valid after one edge", 32'(out_valid_o), 32'd0);
    @(negedge clk_i); #1;
    check("R7 valid after two edges", 32'(out_valid_o), 32'd1);
    check("R4 unity pass", 32'(pix_o), 32'h1234);
    drain();

    // R1 field positions and R4 extremes
    cycle(1, 16'hF800, 16'h07FF, 63, 63, 0, '0, 1);
    cycle(1, 16'h07E0, 16'hF81F, 63, 63, 0, '0, 1);
    cycle(1, 16'h001F, 16'hFFE0, 63, 63, 0, '0, 1);
    // R3 alpha 0 leaves mostly destination, R2 brightness 0
    cycle(1, 16'hFFFF, 16'hFFFF, 0, 0, 0, '0, 1);
    cycle(1, 16'hFFFF, 16'h0000, 0, 63, 0, '0, 1);
    cycle(1, 16'hFFFF, 16'hFFFF, 63, 0, 0, '0, 1);
    // R5 key hit, R6 key disabled with matching value
    cycle(1, 16'hABCD, 16'h1111, 40, 20, 1, 16'hABCD, 1);
    cycle(1, 16'hABCD, 16'h1111, 40, 20, 0, 16'hABCD, 1);
    cycle(1, 16'hABCD, 16'h1111, 40, 20, 1, 16'hABCC, 1);
    drain();

    // R8 directed stall: fill then hold
    cycle(1, 16'h5555, 16'hAAAA, 31, 31, 0, '0, 0);
    cycle(1, 16'h3333, 16'hCCCC, 10, 50, 0, '0, 0);
    cycle(1, 16'h7777, 16'h8888, 20, 5, 0, '0, 0);
    held = pix_o; held_we = wr_en_o;
    for (int i = 0; i < 4; i++) begin
      cycle(1, 16'h7777, 16'h8888, 20, 5, 0, '0, 0);
      check("R8 pix held", 32'(pix_o), 32'(held));
      check("R8 wr_en held", 32'(wr_en_o), 32'(held_we));
      check("R8 valid held", 32'(out_valid_o), 32'd1);
    end
    drain();

    // random traffic with back-pressure, per-pixel settings (R10)
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] s, d, k;
      bit ke;
      s  = 16'($urandom());
      d  = 16'($urandom());
      ke = $urandom_range(0, 1) == 1;
      k  = ($urandom_range(0, 3) == 0) ? s : 16'($urandom());
      cycle($urandom_range(0, 3) != 0, s, d, 6'($urandom()), 6'($urandom()),
            ke, k, $urandom_range(0, 2) != 0);
    end
    drain();
    check("R7 queue empty after drain", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule